// File: doc/BRIEF.md
# Five-Operation Integer ALU

This block is the arithmetic-logic unit of a small load/store datapath. It is purely combinational: two operands and a three-bit operation code go in, and in the same cycle it returns a result word and three status flags. The flags are a zero indication, a signed overflow indication and the carry leaving the top bit.

The unit offers bitwise AND and OR, addition, subtraction and a signed set-on-less-than. All arithmetic goes through one ripple chain of one-bit slices. Each slice forms generate and propagate terms and computes its carry from them. The top bit of the operation code acts as a single B-invert control that also enters the chain as the initial carry, so subtraction is the sum of A, the complement of B, and one.

The less-than decision is taken from that subtraction. The top slice reports the corrected sign of the difference, and bit 0 of the result picks it up. Every other result bit reads zero in that mode. An equality test is a subtraction followed by a look at the zero flag.

Top module: `int_alu32`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of the two operands.
- R2: Code 3'b001 returns the bitwise OR of the two operands.
- R3: Code 3'b010 returns A+B modulo 2^WIDTH; the carry flag is the carry out of the top bit of that sum.
- R4: Code 3'b110 returns A+~B+1 (A−B modulo 2^WIDTH); the carry flag is the carry out of the top bit of that sum, so it is 1 when A ≥ B unsigned.
- R5: For codes 010 and 110 the overflow flag is 1 exactly when both adder inputs (B after optional inversion) have the same sign and the sum's sign differs from it.
- R6: Code 3'b111 returns 1 in bit 0 when A < B as signed two's-complement numbers (correct even when A−B overflows) and 0 in every other bit.
- R7: The zero flag is 1 exactly when all result bits are 0, for every code.
- R8: For codes 000, 001 and 111 the overflow and carry flags are both 0.
- R9: Codes 011, 100 and 101 return an all-zero result, zero flag 1, overflow and carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| opcode | input | 3 | Operation select (bit 2 inverts B and sets the initial carry) |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |
| cout | output | 1 | Carry out of the top bit for add or subtract |

## Verification
The bench builds the unit at its default width of 32. At that width the sign-boundary words 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF can be applied directly, and the cases that matter most are taken from them. These cases cover overflowing sums and differences, a wrap to zero with a carry, and less-than comparisons whose subtraction overflows. The expected result and flags come from whole-word arithmetic in the bench and never from the slice chain.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [2:0] {
        SEL_AND  = 3'd0,
        SEL_OR   = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_LESS = 3'd3,
        SEL_NONE = 3'd4
    } res_sel_e;

    typedef struct packed {
        logic     b_invert;
        res_sel_e sel;
    } alu_ctl_t;

    typedef struct packed {
        logic sum;
        logic carry;
    } slice_out_t;

    // One adder bit built from generate and propagate terms.
    function automatic slice_out_t add_slice(input logic a, input logic b, input logic cin);
        slice_out_t o;
        logic g;
        logic p;
        g       = a & b;
        p       = a | b;
        o.sum   = a ^ b ^ cin;
        o.carry = g | (p & cin);
        return o;
    endfunction

    // Result multiplexer of one slice.
    function automatic logic pick_bit(input res_sel_e sel, input logic a, input logic b,
                                      input logic sum, input logic less);
        logic r;
        case (sel)
            SEL_AND:  r = a & b;
            SEL_OR:   r = a | b;
            SEL_SUM:  r = sum;
            SEL_LESS: r = less;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [2:0] opcode,
    output alu_ctl_t   ctl
);
    always_comb begin
        ctl.b_invert = opcode[2];
        case (opcode)
            3'b000:  ctl.sel = SEL_AND;
            3'b001:  ctl.sel = SEL_OR;
            3'b010:  ctl.sel = SEL_SUM;
            3'b110:  ctl.sel = SEL_SUM;
            3'b111:  ctl.sel = SEL_LESS;
            default: ctl.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/int_alu_chain.sv
module int_alu_chain
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_ctl_t         ctl,
    output logic [WIDTH-1:0] res,
    output logic             carry_top,
    output logic             ovf_raw
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] bx;
    logic [WIDTH-1:0] sums;
    logic             set_bit;

    always_comb begin
        logic       c;
        slice_out_t so;
        c = ctl.b_invert;
        for (int i = 0; i < WIDTH; i++) begin
            bx[i]   = b[i] ^ ctl.b_invert;
            so      = add_slice(a[i], bx[i], c);
            sums[i] = so.sum;
            c       = so.carry;
        end
        carry_top = c;
        ovf_raw   = (a[MSB] == bx[MSB]) && (sums[MSB] != a[MSB]);
        set_bit   = sums[MSB] ^ ovf_raw;
        for (int i = 0; i < WIDTH; i++) begin
            res[i] = pick_bit(ctl.sel, a[i], bx[i], sums[i], (i == 0) ? set_bit : 1'b0);
        end
    end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctl_t         ctl,
    input  logic [WIDTH-1:0] res,
    input  logic             carry_top,
    input  logic             ovf_raw,
    output logic             zero,
    output logic             ovf,
    output logic             cout
);
    logic arith;

    always_comb begin
        arith = (ctl.sel == SEL_SUM);
        zero  = ~|res;
        ovf   = arith & ovf_raw;
        cout  = arith & carry_top;
    end
endmodule

// File: rtl/int_alu32.sv
module int_alu32
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       opcode,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf,
    output logic             cout
);
    alu_ctl_t   ctl;
    logic       carry_top;
    logic       ovf_raw;

    int_alu_decode u_decode (
        .opcode (opcode),
        .ctl    (ctl)
    );

    int_alu_chain #(.WIDTH(WIDTH)) u_chain (
        .a         (opa),
        .b         (opb),
        .ctl       (ctl),
        .res       (result),
        .carry_top (carry_top),
        .ovf_raw   (ovf_raw)
    );

    int_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .ctl       (ctl),
        .res       (result),
        .carry_top (carry_top),
        .ovf_raw   (ovf_raw),
        .zero      (zero),
        .ovf       (ovf),
        .cout      (cout)
    );

    always_comb begin
        logic [WIDTH:0] wide;
        wide = {1'b0, opa} + {1'b0, opb};
        if (opcode == 3'b010)
            assert_add_R3: assert ({cout, result} == wide);
        if (opcode == 3'b000 || opcode == 3'b001 || opcode == 3'b111)
            assert_logic_flags_R8: assert (!ovf && !cout);
        if (opcode == 3'b111)
            assert_slt_upper_R6: assert (result[WIDTH-1:1] == '0);
        if (opcode == 3'b011 || opcode == 3'b100 || opcode == 3'b101)
            assert_unused_R9: assert (result == '0 && zero && !ovf && !cout);
        assert_zero_R7: assert (zero == (result == '0));
    end
endmodule

// File: tb/int_alu32_test.sv
module int_alu32_test;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] r;
        logic         z;
        logic         v;
        logic         c;
        string        req;
    } exp_t;

    logic         clk = 0;
    logic         rst = 1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [2:0]   opcode = 3'b000;
    logic [W-1:0] result;
    logic         zero, ovf, cout;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    int_alu32 #(.WIDTH(W)) uut (
        .opa(opa), .opb(opb), .opcode(opcode),
        .result(result), .zero(zero), .ovf(ovf), .cout(cout)
    );

    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, string req);
        exp_t e;
        logic [W:0] t;
        e.r = '0; e.v = 0; e.c = 0; e.req = req;
        case (op)
            3'b000: e.r = a & b;
            3'b001: e.r = a | b;
            3'b010: begin
                t = {1'b0, a} + {1'b0, b};
                e.r = t[W-1:0]; e.c = t[W];
                e.v = (a[W-1] == b[W-1]) && (e.r[W-1] != a[W-1]);
            end
            3'b110: begin
                t = {1'b0, a} + {1'b0, ~b} + 1;
                e.r = t[W-1:0]; e.c = t[W];
                e.v = (a[W-1] != b[W-1]) && (e.r[W-1] != a[W-1]);
            end
            3'b111: e.r = ($signed(a) < $signed(b)) ? 1 : 0;
            default: e.r = '0;
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, string req);
        @(posedge clk);
        opa = a; opb = b; opcode = op;
        q.push_back(model(a, b, op, req));
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (result !== e.r || zero !== e.z || ovf !== e.v || cout !== e.c) begin
                    errors++;
                    $display("FAIL %s: got r=%h z=%b v=%b c=%b expected r=%h z=%b v=%b c=%b",
                             e.req, result, zero, ovf, cout, e.r, e.z, e.v, e.c);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        rst = 0;
        drive(32'h0, 32'h0, 3'b000, "reset-state R7");
        drive(32'hFF00FF00, 32'h0F0F0F0F, 3'b000, "R1 and R8");
        drive(32'hF0F0F0F0, 32'h0F0F0F0F, 3'b000, "R1 R7 zero");
        drive(32'hFF000000, 32'h00000F0F, 3'b001, "R2 or");
        drive(32'h00000001, 32'h00000002, 3'b010, "R3 add");
        drive(32'hFFFFFFFF, 32'h00000001, 3'b010, "R3 R7 carry wrap");
        drive(32'h7FFFFFFF, 32'h00000001, 3'b010, "R5 add ovf");
        drive(32'h80000000, 32'h80000000, 3'b010, "R5 neg ovf");
        drive(32'h00000005, 32'h00000003, 3'b110, "R4 sub");
        drive(32'h00000003, 32'h00000005, 3'b110, "R4 sub borrow");
        drive(32'h12345678, 32'h12345678, 3'b110, "R4 R7 equal");
        drive(32'h80000000, 32'h00000001, 3'b110, "R5 sub ovf");
        drive(32'h7FFFFFFF, 32'hFFFFFFFF, 3'b110, "R5 sub ovf pos");
        drive(32'h00000002, 32'h00000003, 3'b111, "R6 slt true");
        drive(32'hFFFFFFFF, 32'h00000001, 3'b111, "R6 slt neg");
        drive(32'h00000003, 32'h00000002, 3'b111, "R6 R8 slt false");
        drive(32'h80000000, 32'h00000001, 3'b111, "R6 slt ovf true");
        drive(32'h7FFFFFFF, 32'h80000000, 3'b111, "R6 slt ovf false");
        drive(32'h00000007, 32'h00000007, 3'b111, "R6 slt equal");
        drive(32'hFFFFFFFF, 32'h00000001, 3'b011, "R9 code 011");
        drive(32'hFFFFFFFF, 32'hFFFFFFFF, 3'b100, "R9 code 100");
        drive(32'h7FFFFFFF, 32'h00000001, 3'b101, "R9 code 101");
        for (int i = 0; i < 16; i++)
            drive(32'h9E3779B9 * (i + 1), 32'h7F4A7C15 * (i + 3), 3'b010, "R3 R5 sweep");
        for (int i = 0; i < 16; i++)
            drive(32'h85EBCA6B * (i + 2), 32'hC2B2AE35 * (i + 1), 3'b110, "R4 R5 sweep");
        for (int i = 0; i < 16; i++)
            drive(32'h27D4EB2F * (i + 5), 32'h165667B1 * (i + 7), 3'b111, "R6 sweep");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule